// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit shifts or rotates the low byte, word or long of a 32-bit data value by a bit count, taking one bit position per clock. Eight operations are offered: logical and arithmetic shifts in both directions, plain rotates in both directions, and rotates that pass through an extend bit (X) in both directions. Alongside the result it produces the extend, negative, zero, overflow and carry flags and the number of cycles the operation is charged.

The count comes either from a 3-bit immediate field, where 0 stands for 8, or from the low six bits of a 32-bit count register. A caller pulses `startReq` with the operands. The unit then works for as many clocks as the count and pulses `doneStb` when the result and flags are final. Results stay on the outputs until the next accepted start. Requests that arrive while an operation is running are dropped.

Top module: `srot_unit`

## Requirements
- R1: With `countFromReg` = 0, the count is `countImm`, and an immediate field of 0 gives a count of 8.
- R2: With `countFromReg` = 1, the count is `countReg[5:0]` (0 to 63), and the higher register bits are ignored.
- R3: Operations 0 (logical left) and 2 (arithmetic left) move a zero into bit 0 on every step. The bit leaving the lane MSB goes to both C and X.
- R4: Operation 1 (logical right) fills the lane MSB with zero, and operation 3 (arithmetic right) fills it with the old lane MSB. Both move the bit leaving bit 0 into both C and X.
- R5: Operations 4 (rotate left) and 5 (rotate right) feed the wrapping bit into the vacated end and into C, and they leave X unchanged.
- R6: Operations 6 (rotate left through X) and 7 (rotate right through X) form a ring of lane-width plus one bits. The old X enters the vacated end, and the bit leaving the lane becomes both the new X and C.
- R7: Before the first step, C equals the incoming X for operations 6 and 7 and is 0 for all other operations. X starts equal to the incoming X, and V is always 0. With a count of 0, the data and X are returned unchanged.
- R8: N is the lane MSB of the final result, and Z is 1 exactly when the final lane is all zeros.
- R9: `cycleCost` is 6 + 2×count for byte and word sizes and 8 + 2×count for long size.
- R10: Size codes are 0 for byte (bits 7:0), 1 for word (bits 15:0), and 2 or 3 for long (bits 31:0). Result bits above the lane equal the input data bits.
- R11: `doneStb` is a one-cycle pulse. It appears in the cycle after the start edge plus count clocks, which for a count of 0 is the cycle right after the start edge.
- R12: A `startReq` that arrives while an operation is running is ignored. It produces no additional `doneStb` and does not change the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, accepted only when idle |
| opSel | input | 3 | Operation code (see R3 to R6) |
| sizeSel | input | 2 | Lane size code (see R10) |
| countImm | input | 3 | Immediate count field |
| countFromReg | input | 1 | 1 selects the count register as the count source |
| countReg | input | 32 | Count register value |
| dataIn | input | 32 | Data value to shift |
| xIn | input | 1 | Incoming extend flag |
| result | output | 32 | Shifted data |
| xOut | output | 1 | Extend flag |
| nOut | output | 1 | Negative flag |
| zOut | output | 1 | Zero flag |
| vOut | output | 1 | Overflow flag |
| cOut | output | 1 | Carry flag |
| doneStb | output | 1 | Completion pulse |
| cycleCost | output | 8 | Charged cycle count |

## Verification
Each of the eight operations runs at least once, on data patterns whose lane MSB, bit 0 and upper bytes differ. These patterns separate a zero fill from a sign fill and a wrap from a ring through X, and they expose any leak into bits above the lane. Both count sources are used, including the immediate 0 that means 8, a register value with set bits above bit 5, register counts of 0 and 63, and size code 3. These counts pin down the count decode, the starting value of C, and the cost and done timing. A second start issued in the middle of a long operation shows whether busy requests are dropped.

// File: rtl/srot_pkg.sv
package srot_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0, OP_LSR = 3'd1, OP_ASL = 3'd2, OP_ASR = 3'd3,
    OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RXL = 3'd6, OP_RXR = 3'd7
  } srotOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_LONG2 = 2'd3
  } srotSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } srotCtl_t;
endpackage

// File: rtl/srot_ctrl.sv
module srot_ctrl
  import srot_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [2:0]       countImm,
  input  logic             countFromReg,
  input  logic [REG_W-1:0] countReg,
  output srotCtl_t         ctl,
  output logic [CNT_W-1:0] effCount,
  output logic             doneStb
);
  logic             busy;
  logic [CNT_W-1:0] remain;

  always_comb begin
    if (countFromReg) effCount = countReg[CNT_W-1:0];
    else if (countImm == 3'd0) effCount = CNT_W'(8);
    else effCount = CNT_W'(countImm);
  end

  always_comb begin
    ctl.load = startReq && !busy;
    ctl.step = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      remain  <= '0;
      doneStb <= 1'b0;
    end else begin
      doneStb <= 1'b0;
      if (ctl.load) begin
        if (effCount == '0) doneStb <= 1'b1;
        else begin
          busy   <= 1'b1;
          remain <= effCount;
        end
      end else if (busy) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) begin
          busy    <= 1'b0;
          doneStb <= 1'b1;
        end
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);
  // R11
  zero_count_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && effCount == '0) |=> (doneStb && !busy));
  // R12
  busy_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && remain > CNT_W'(1)) |=> (busy && remain == $past(remain) - 1'b1));
endmodule

// File: rtl/srot_datapath.sv
module srot_datapath
  import srot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  srotCtl_t          ctl,
  input  logic [2:0]        opSel,
  input  logic [1:0]        sizeSel,
  input  logic [CNT_W-1:0]  effCount,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              xIn,
  output logic [DATA_W-1:0] result,
  output logic              xOut,
  output logic              nOut,
  output logic              zOut,
  output logic              vOut,
  output logic              cOut,
  output logic [COST_W-1:0] cycleCost
);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [COST_W-1:0] BASE_SHORT = COST_W'(6);
  localparam logic [COST_W-1:0] BASE_LONG  = COST_W'(8);

  logic [DATA_W-1:0] dataReg, laneMask, lane, shifted, nextData, fillVec;
  logic [IDX_W-1:0]  msbIdx;
  logic              xReg, cReg, msbBit, lsbBit, fillBit, outBit, isLeft;
  srotOp_e           opReg;
  srotSize_e         sizeReg;

  always_comb begin
    case (sizeReg)
      SZ_BYTE: begin laneMask = DATA_W'({BYTE_W{1'b1}}); msbIdx = IDX_W'(BYTE_W-1); end
      SZ_WORD: begin laneMask = DATA_W'({WORD_W{1'b1}}); msbIdx = IDX_W'(WORD_W-1); end
      default: begin laneMask = '1;                       msbIdx = IDX_W'(DATA_W-1); end
    endcase
    lane   = dataReg & laneMask;
    msbBit = dataReg[msbIdx];
    lsbBit = dataReg[0];
    isLeft = !opReg[0];
    case (opReg)
      OP_ASR:          fillBit = msbBit;
      OP_ROL:          fillBit = msbBit;
      OP_ROR:          fillBit = lsbBit;
      OP_RXL, OP_RXR:  fillBit = xReg;
      default:         fillBit = 1'b0;
    endcase
    fillVec  = DATA_W'(fillBit) << msbIdx;
    shifted  = isLeft ? ((lane << 1) | DATA_W'(fillBit)) : ((lane >> 1) | fillVec);
    nextData = (dataReg & ~laneMask) | (shifted & laneMask);
    outBit   = isLeft ? msbBit : lsbBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      xReg      <= 1'b0;
      cReg      <= 1'b0;
      opReg     <= OP_LSL;
      sizeReg   <= SZ_BYTE;
      cycleCost <= '0;
    end else if (ctl.load) begin
      dataReg   <= dataIn;
      xReg      <= xIn;
      cReg      <= (opSel == OP_RXL || opSel == OP_RXR) ? xIn : 1'b0;
      opReg     <= srotOp_e'(opSel);
      sizeReg   <= srotSize_e'(sizeSel);
      cycleCost <= (sizeSel[1] ? BASE_LONG : BASE_SHORT) + (COST_W'(effCount) << 1);
    end else if (ctl.step) begin
      dataReg <= nextData;
      cReg    <= outBit;
      if (opReg != OP_ROL && opReg != OP_ROR) xReg <= outBit;
    end
  end

  assign result = dataReg;
  assign xOut   = xReg;
  assign cOut   = cReg;
  assign vOut   = 1'b0;
  assign nOut   = msbBit;
  assign zOut   = (lane == '0);

  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && sizeReg == SZ_BYTE) |=> (dataReg[DATA_W-1:BYTE_W] == $past(dataReg[DATA_W-1:BYTE_W])));
  // R5
  rot_x_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && (opReg == OP_ROL || opReg == OP_ROR)) |=> $stable(xReg));
  // R6
  ring_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && opReg == OP_RXL) |=> (dataReg[0] == $past(xReg)));
  // R3
  left_cx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && (opReg == OP_LSL || opReg == OP_ASL)) |=> (cReg == xReg && dataReg[0] == 1'b0));
endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [2:0]        opSel,
  input  logic [1:0]        sizeSel,
  input  logic [2:0]        countImm,
  input  logic              countFromReg,
  input  logic [DATA_W-1:0] countReg,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              xIn,
  output logic [DATA_W-1:0] result,
  output logic              xOut,
  output logic              nOut,
  output logic              zOut,
  output logic              vOut,
  output logic              cOut,
  output logic              doneStb,
  output logic [COST_W-1:0] cycleCost
);
  srotCtl_t         ctl;
  logic [CNT_W-1:0] effCount;

  srot_ctrl #(.CNT_W(CNT_W), .REG_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .countImm(countImm),
    .countFromReg(countFromReg), .countReg(countReg), .ctl(ctl),
    .effCount(effCount), .doneStb(doneStb)
  );

  srot_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .COST_W(COST_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSel(opSel), .sizeSel(sizeSel),
    .effCount(effCount), .dataIn(dataIn), .xIn(xIn), .result(result),
    .xOut(xOut), .nOut(nOut), .zOut(zOut), .vOut(vOut), .cOut(cOut),
    .cycleCost(cycleCost)
  );
endmodule

// File: tb/test_srot_unit.sv
module test_srot_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [2:0]  countImm = '0;
  logic        countFromReg = 1'b0;
  logic [31:0] countReg = '0;
  logic [31:0] dataIn = '0;
  logic        xIn = 1'b0;
  logic [31:0] result;
  logic        xOut, nOut, zOut, vOut, cOut, doneStb;
  logic [7:0]  cycleCost;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pushed = 0;
  int popped = 0;

  typedef struct {
    logic [31:0] res;
    logic        x, n, z, v, c;
    int          cost;
    int          doneCyc;
    string       tag;
  } item_t;
  item_t expQ[$];

  srot_unit i_srot_unit (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opSel(opSel), .sizeSel(sizeSel),
    .countImm(countImm), .countFromReg(countFromReg), .countReg(countReg),
    .dataIn(dataIn), .xIn(xIn), .result(result), .xOut(xOut), .nOut(nOut),
    .zOut(zOut), .vOut(vOut), .cOut(cOut), .doneStb(doneStb), .cycleCost(cycleCost)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic item_t model(input int op, input int size, input int imm,
                                  input bit fromReg, input logic [31:0] creg,
                                  input logic [31:0] data, input bit x, input string tag);
    item_t it;
    int w, n;
    logic [31:0] d;
    bit c, o;
    w = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    n = fromReg ? int'(creg[5:0]) : (imm == 0 ? 8 : imm);
    d = data;
    c = (op == 6 || op == 7) ? x : 1'b0;
    for (int s = 0; s < n; s++) begin
      if (op % 2 == 0) begin
        o = d[w-1];
        for (int b = w-1; b > 0; b--) d[b] = d[b-1];
        d[0] = (op == 4) ? o : (op == 6) ? x : 1'b0;
      end else begin
        o = d[0];
        for (int b = 0; b < w-1; b++) d[b] = d[b+1];
        d[w-1] = (op == 3) ? d[w-1] : (op == 5) ? o : (op == 7) ? x : 1'b0;
      end
      c = o;
      if (op != 4 && op != 5) x = o;
    end
    it.res = d;
    it.x = x;
    it.c = c;
    it.v = 1'b0;
    it.n = d[w-1];
    it.z = 1'b1;
    for (int b = 0; b < w; b++) if (d[b]) it.z = 1'b0;
    it.cost = ((size >= 2) ? 8 : 6) + 2 * n;
    it.doneCyc = n;
    it.tag = tag;
    return it;
  endfunction

  // driver: push expected item, issue start
  task automatic run(input int op, input int size, input int imm, input bit fromReg,
                     input logic [31:0] creg, input logic [31:0] data, input bit x,
                     input string tag, input int busyPoke);
    item_t it;
    int target;
    it = model(op, size, imm, fromReg, creg, data, x, tag);
    @(posedge clk); #2;
    it.doneCyc = cyc + 1 + it.doneCyc;
    expQ.push_back(it);
    pushed++;
    target = pushed;
    opSel = 3'(op); sizeSel = 2'(size); countImm = 3'(imm);
    countFromReg = fromReg; countReg = creg; dataIn = data; xIn = x;
    startReq = 1'b1;
    @(posedge clk); #2;
    startReq = 1'b0;
    if (busyPoke > 0) begin
      repeat (busyPoke) @(posedge clk);
      #2;
      opSel = 3'd1; sizeSel = 2'd2; countImm = 3'd1; countFromReg = 1'b0;
      dataIn = 32'hFFFF_FFFF; xIn = ~x;
      startReq = 1'b1;
      @(posedge clk); #2;
      startReq = 1'b0;
    end
    while (popped < target) @(negedge clk);
  endtask

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (rstN && doneStb) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12", "unexpected done pulse", 32'(cyc), 32'hFFFF_FFFF);
      end else begin
        item_t e;
        e = expQ.pop_front();
        popped++;
        check(result == e.res, e.tag, "result", result, e.res);
        check(xOut == e.x, e.tag, "X flag", 32'(xOut), 32'(e.x));
        check(cOut == e.c, e.tag, "C flag", 32'(cOut), 32'(e.c));
        check(vOut == e.v, "R7", "V flag", 32'(vOut), 32'(e.v));
        check(nOut == e.n && zOut == e.z, "R8", "N,Z flags",
              {30'd0, nOut, zOut}, {30'd0, e.n, e.z});
        check(int'(cycleCost) == e.cost, "R9", "cycle cost", 32'(cycleCost), 32'(e.cost));
        check(cyc == e.doneCyc, "R11", "done cycle", 32'(cyc), 32'(e.doneCyc));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 32'(cyc), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(result == 32'd0 && doneStb == 1'b0 && cycleCost == 8'd0 && xOut == 1'b0,
          "R11", "reset state", {result[29:0], doneStb, xOut}, 32'd0);

    run(0, 0, 3, 0, 32'd0,        32'h1234_56C1, 1'b0, "R3",  0);
    run(1, 0, 0, 0, 32'd0,        32'hAAAA_AA81, 1'b0, "R1",  0);
    run(2, 1, 0, 1, 32'hFFFF_FFC7, 32'h0000_81FF, 1'b0, "R2",  0);
    run(3, 1, 2, 0, 32'd0,        32'hFFFF_8004, 1'b0, "R4",  0);
    run(1, 2, 0, 1, 32'd63,       32'h8000_0001, 1'b1, "R4",  0);
    run(4, 0, 1, 0, 32'd0,        32'h55AA_0081, 1'b1, "R5",  0);
    run(5, 1, 4, 0, 32'd0,        32'h1234_000F, 1'b0, "R5",  0);
    run(6, 2, 5, 0, 32'd0,        32'h8000_0000, 1'b1, "R6",  0);
    run(7, 0, 0, 0, 32'd0,        32'hFFFF_FF00, 1'b1, "R6",  0);
    run(6, 0, 0, 1, 32'h0000_0040, 32'hDEAD_BE00, 1'b1, "R7",  0);
    run(0, 2, 0, 1, 32'd0,        32'h8765_4321, 1'b1, "R7",  0);
    run(4, 3, 6, 0, 32'd0,        32'hF000_000F, 1'b0, "R10", 0);
    run(3, 0, 7, 0, 32'd0,        32'hCAFE_F080, 1'b0, "R10", 0);
    run(1, 2, 0, 1, 32'd20,       32'h0F0F_F0F0, 1'b0, "R12", 3);

    repeat (30) @(posedge clk);
    #2;
    check(pushed == popped && expQ.size() == 0, "R12", "done pulse count",
          32'(popped), 32'(pushed));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule